// File: doc/BRIEF.md
# Port-Aware Sleep Depth Controller

This block decides when a physical-layer device may drop into a low-power state, how deep that state goes, and when it must climb back out. It watches the host-interface condition (whether the link-side interface has already been shut down), the status of its single cable port, a port-interrupt enable bit, a raw power-status input from the link side and three port event pulses. From these it drives enables for the internal clock generators, for a general tier of reference circuits and for the connection-detect reference, and reports the current sleep depth.

Sleep is only allowed while the host interface is shut down and the port carries no live traffic. The depth follows the port: when a new cable connection could still need to be noticed the detect reference stays powered, and when the port is unplugged, or shut off with its interrupt masked, everything is dropped. A rising power-status input, a relevant port event or the loss of the sleep condition starts a wake, during which all enables return. A counter in slow-clock cycles bounds the time until the clock-ready input confirms the wake, and raises a sticky error flag when that bound is exceeded.

Top module: `sleep_depth_ctrl`

## Requirements
- R1: After reset the block is awake: clkgen_en, ref_core_en and ref_detect_en are 1, sleep_level is 2'b00 and wake_timeout is 0.
- R2: While awake, the block enters sleep at the next clock edge when if_disabled is 1, status_in is 0 and the port is inactive (port_connected is 0, or port_disabled is 1, or port_suspended is 1); otherwise it stays awake.
- R3: While asleep, clkgen_en and ref_core_en are 0.
- R4: Light sleep: while asleep with port_connected 1 and not (port_disabled 1 and port_irq_en 0), sleep_level is 2'b01 and ref_detect_en is 1.
- R5: Deep sleep: while asleep with port_connected 0, or port_disabled 1 with port_irq_en 0, sleep_level is 2'b10 and ref_detect_en is 0; the depth follows the port inputs in the same cycle.
- R6: While asleep, status_in at 1, or the loss of any sleep condition of R2, moves the block to waking at the next edge; while waking sleep_level is 2'b11 and all three enables are 1.
- R7: A qualifying event (evt_bias with port_suspended 1, evt_disconnect with port_suspended 1, evt_connect with port_disabled 0) seen while asleep or waking is latched at the edge; a latched event moves a sleeping block to waking at the following edge, so a one-cycle pulse wakes it two edges later.
- R8: Event pulses that do not qualify, and any event pulse seen while awake, have no effect: a later sleep is not cut short by them.
- R9: While waking, clk_ready at 1 returns the block to awake at the next edge and discards any latched event.
- R10: If clk_ready stays 0 for WAKE_LIMIT consecutive cycles in the waking state, wake_timeout becomes 1 at the edge ending the WAKE_LIMIT-th cycle and stays 1 through the return to awake; clk_ready in any of the first WAKE_LIMIT cycles prevents it.
- R11: wake_timeout returns to 0 at the edge where the block next enters sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_disabled | input | 1 | Host interface is in its shut-down state |
| port_connected | input | 1 | Cable is present on the port |
| port_disabled | input | 1 | Port is switched off |
| port_suspended | input | 1 | Port is suspended |
| port_irq_en | input | 1 | Port interrupt enable bit |
| status_in | input | 1 | Raw power-status input from the link side |
| evt_bias | input | 1 | Pulse: incoming bias seen on the port |
| evt_disconnect | input | 1 | Pulse: cable removal seen on the port |
| evt_connect | input | 1 | Pulse: new cable seen on the port |
| clk_ready | input | 1 | System clock running and interface initialised |
| clkgen_en | output | 1 | Enable for internal clock generators |
| ref_core_en | output | 1 | Enable for general reference circuits |
| ref_detect_en | output | 1 | Enable for connection-detect reference |
| sleep_level | output | 2 | 00 awake, 01 light sleep, 10 deep sleep, 11 waking |
| wake_timeout | output | 1 | Sticky wake latency error flag |

## Verification
The hardest situation to reach is a wake that overruns its latency bound and then a clean wake that lands on exactly the last permitted cycle, because random clock-ready traffic almost always answers early. Directed sequences hold clk_ready low through a full WAKE_LIMIT window, then repeat the wake with clk_ready raised in precisely the final cycle, and follow with a sleep entry to see the flag clear. Short event pulses arriving while the port status makes them irrelevant, or while awake, are also placed deliberately before a long quiet sleep so that any stray latch would show up as an early wake; random traffic biased toward sleep covers the rest against a bench model.

// File: rtl/sleep_depth_pkg.sv
// Shared types for the sleep depth controller.
// Assumes: a single slow always-on clock domain.
package sleep_depth_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'b00,
        ST_SLEEP  = 2'b01,
        ST_WAKING = 2'b10
    } slp_state_e;

    localparam logic [1:0] LVL_ACTIVE = 2'b00;
    localparam logic [1:0] LVL_LIGHT  = 2'b01;
    localparam logic [1:0] LVL_DEEP   = 2'b10;
    localparam logic [1:0] LVL_WAKE   = 2'b11;

endpackage

// File: rtl/port_cond_eval.sv
// Combinational evaluation of the port condition: whether sleep is
// permitted, whether it must be the deepest level, and whether an
// incoming event pulse is relevant to the present port status.
// Assumes: all inputs are already synchronous to clk.
module port_cond_eval (
    input  logic if_disabled,
    input  logic port_connected,
    input  logic port_disabled,
    input  logic port_suspended,
    input  logic port_irq_en,
    input  logic status_in,
    input  logic evt_bias,
    input  logic evt_disconnect,
    input  logic evt_connect,
    output logic sleep_ok,
    output logic deep_ok,
    output logic qual_evt
);
    logic port_idle;

    // Derive sleep permission, depth and event relevance.
    always_comb begin
        port_idle = !port_connected || port_disabled || port_suspended;
        sleep_ok  = if_disabled && port_idle && !status_in;
        deep_ok   = !port_connected || (port_disabled && !port_irq_en);
        qual_evt  = (evt_bias && port_suspended)
                 || (evt_disconnect && port_suspended)
                 || (evt_connect && !port_disabled);
    end
endmodule

// File: rtl/wake_event_latch.sv
// Holds a relevant port event from the moment it is seen (asleep or
// waking) until the wake completes, so that a one-cycle pulse is kept.
// Assumes: events seen while awake are of no interest.
module wake_event_latch
    import sleep_depth_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slp_state_e state,
    input  logic       clk_ready,
    input  logic       qual_evt,
    output logic       pend
);
    // Capture relevant events outside the awake state; clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (state == ST_WAKING && clk_ready) begin
            pend <= 1'b0;
        end else if (state != ST_AWAKE) begin
            pend <= pend || qual_evt;
        end
    end

    // R8: no event survives into the awake state.
    assert_no_pend_awake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE) |-> !pend);

    // R9: a completed wake leaves nothing latched.
    assert_pend_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKING && clk_ready) |=> !pend);
endmodule

// File: rtl/sleep_state_fsm.sv
// Three-state sequencer: awake, asleep, waking. Sleep entry needs the
// permit from the port evaluation; exit follows loss of that permit or
// a latched event; waking ends on clock-ready.
// Assumes: sleep_ok already folds in the status input.
module sleep_state_fsm
    import sleep_depth_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_ok,
    input  logic       pend,
    input  logic       clk_ready,
    output slp_state_e state,
    output logic       enter_sleep
);
    slp_state_e state_n;

    // Next-state selection.
    always_comb begin
        state_n     = state;
        enter_sleep = 1'b0;
        unique case (state)
            ST_AWAKE: if (sleep_ok) begin
                state_n     = ST_SLEEP;
                enter_sleep = 1'b1;
            end
            ST_SLEEP:  if (!sleep_ok || pend) state_n = ST_WAKING;
            ST_WAKING: if (clk_ready) state_n = ST_AWAKE;
            default:   state_n = ST_AWAKE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_AWAKE;
        else        state <= state_n;
    end

    // R2: no sleep without permission.
    assert_no_sleep_unpermitted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE && !sleep_ok) |=> (state == ST_AWAKE));

    // R7: a latched event always ends sleep.
    assert_pend_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && pend) |=> (state == ST_WAKING));

    // R9: clock-ready completes the wake.
    assert_ready_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKING && clk_ready) |=> (state == ST_AWAKE));
endmodule

// File: rtl/wake_latency_timer.sv
// Counts cycles spent waking without clock-ready and raises a sticky
// error flag after WAKE_LIMIT of them; the flag clears on sleep entry.
// Assumes: WAKE_LIMIT >= 2.
module wake_latency_timer
    import sleep_depth_pkg::*;
#(
    parameter int WAKE_LIMIT = 240
) (
    input  logic       clk,
    input  logic       rst_n,
    input  slp_state_e state,
    input  logic       clk_ready,
    input  logic       enter_sleep,
    output logic       timeout
);
    localparam int CNT_W = $clog2(WAKE_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_LIMIT - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WAKE_LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic             waiting;

    // Waiting means waking with no confirmation this cycle.
    always_comb waiting = (state == ST_WAKING) && !clk_ready;

    // Saturating wait counter, zero outside a pending wake.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (!waiting)           cnt_q <= '0;
        else if (cnt_q != CNT_SAT)   cnt_q <= cnt_q + 1'b1;
    end

    // Sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                           timeout <= 1'b0;
        else if (enter_sleep)                 timeout <= 1'b0;
        else if (waiting && cnt_q == CNT_LAST) timeout <= 1'b1;
    end

    // R10: the flag only rises out of a wake.
    assert_timeout_from_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> ($past(state) == ST_WAKING));

    // R10: a confirmed wake never sets the flag.
    assert_ready_no_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKING && clk_ready && !timeout) |=> !timeout);

    // R11: entering sleep clears the flag.
    assert_clear_on_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        enter_sleep |=> !timeout);
endmodule

// File: rtl/sleep_depth_ctrl.sv
// Top of the sleep depth controller: evaluates the port, sequences
// sleep and wake, bounds the wake latency and decodes the enables and
// the sleep level from the state and the present port depth.
// Assumes: one slow always-on clock; inputs synchronous to it.
module sleep_depth_ctrl
    import sleep_depth_pkg::*;
#(
    parameter int WAKE_LIMIT = 240
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       if_disabled,
    input  logic       port_connected,
    input  logic       port_disabled,
    input  logic       port_suspended,
    input  logic       port_irq_en,
    input  logic       status_in,
    input  logic       evt_bias,
    input  logic       evt_disconnect,
    input  logic       evt_connect,
    input  logic       clk_ready,
    output logic       clkgen_en,
    output logic       ref_core_en,
    output logic       ref_detect_en,
    output logic [1:0] sleep_level,
    output logic       wake_timeout
);
    slp_state_e state;
    logic       sleep_ok;
    logic       deep_ok;
    logic       qual_evt;
    logic       pend;
    logic       enter_sleep;

    port_cond_eval u_cond (
        .if_disabled    (if_disabled),
        .port_connected (port_connected),
        .port_disabled  (port_disabled),
        .port_suspended (port_suspended),
        .port_irq_en    (port_irq_en),
        .status_in      (status_in),
        .evt_bias       (evt_bias),
        .evt_disconnect (evt_disconnect),
        .evt_connect    (evt_connect),
        .sleep_ok       (sleep_ok),
        .deep_ok        (deep_ok),
        .qual_evt       (qual_evt)
    );

    wake_event_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .clk_ready (clk_ready),
        .qual_evt  (qual_evt),
        .pend      (pend)
    );

    sleep_state_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_ok    (sleep_ok),
        .pend        (pend),
        .clk_ready   (clk_ready),
        .state       (state),
        .enter_sleep (enter_sleep)
    );

    wake_latency_timer #(.WAKE_LIMIT(WAKE_LIMIT)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .clk_ready   (clk_ready),
        .enter_sleep (enter_sleep),
        .timeout     (wake_timeout)
    );

    // Decode enables and level from state and present depth.
    always_comb begin
        clkgen_en     = 1'b1;
        ref_core_en   = 1'b1;
        ref_detect_en = 1'b1;
        sleep_level   = LVL_ACTIVE;
        unique case (state)
            ST_SLEEP: begin
                clkgen_en     = 1'b0;
                ref_core_en   = 1'b0;
                ref_detect_en = !deep_ok;
                sleep_level   = deep_ok ? LVL_DEEP : LVL_LIGHT;
            end
            ST_WAKING: sleep_level = LVL_WAKE;
            default:   sleep_level = LVL_ACTIVE;
        endcase
    end

    // R3: no clocks or core references while asleep.
    assert_clk_off_asleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_level == LVL_LIGHT || sleep_level == LVL_DEEP) |-> (!clkgen_en && !ref_core_en));

    // R5: deepest level drops the detect reference too.
    assert_deep_detect_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_level == LVL_DEEP) |-> !ref_detect_en);

    // R6: status input ends sleep at the next edge.
    assert_status_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && status_in) |=> (sleep_level == LVL_WAKE));
endmodule

// File: tb/sleep_depth_ctrl_tb.sv
module sleep_depth_ctrl_tb;
    localparam int LIMIT = 240;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ifd = 0, con = 0, dis = 0, sus = 0, irq = 0, st = 0;
    logic eb = 0, ed = 0, ec = 0, rdy = 0;
    // Shadow values chosen by stimulus, applied at the falling edge.
    logic s_ifd = 0, s_con = 0, s_dis = 0, s_sus = 0, s_irq = 0, s_st = 0;
    logic s_eb = 0, s_ed = 0, s_ec = 0, s_rdy = 0;

    logic       clkgen_en, ref_core_en, ref_detect_en, wake_timeout;
    logic [1:0] sleep_level;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench model: 0 awake, 1 asleep, 2 waking.
    int m_st = 0;
    int m_cnt = 0;
    bit m_pend = 0;
    bit m_to = 0;

    always #4 clk = ~clk;

    sleep_depth_ctrl #(.WAKE_LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .if_disabled(ifd), .port_connected(con),
        .port_disabled(dis), .port_suspended(sus), .port_irq_en(irq),
        .status_in(st), .evt_bias(eb), .evt_disconnect(ed), .evt_connect(ec),
        .clk_ready(rdy), .clkgen_en(clkgen_en), .ref_core_en(ref_core_en),
        .ref_detect_en(ref_detect_en), .sleep_level(sleep_level),
        .wake_timeout(wake_timeout)
    );

    function automatic bit f_entry();
        return ifd && (!con || dis || sus) && !st;
    endfunction

    function automatic bit f_deep();
        return !con || (dis && !irq);
    endfunction

    function automatic bit f_qual();
        return (eb && sus) || (ed && sus) || (ec && !dis);
    endfunction

    // Expected {clkgen, core, detect, level, timeout}.
    function automatic logic [5:0] f_exp();
        if (m_st == 1)
            return {1'b0, 1'b0, !f_deep(), (f_deep() ? 2'b10 : 2'b01), m_to};
        if (m_st == 2)
            return {3'b111, 2'b11, m_to};
        return {3'b111, 2'b00, m_to};
    endfunction

    function automatic void f_advance();
        bit q;
        q = f_qual();
        case (m_st)
            0: if (f_entry()) begin m_st = 1; m_to = 0; end
            1: begin
                if (!f_entry() || m_pend) begin m_st = 2; m_cnt = 0; end
                m_pend = m_pend || q;
            end
            default: begin
                if (rdy) begin
                    m_st = 0; m_pend = 0; m_cnt = 0;
                end else begin
                    if (m_cnt == LIMIT - 1) m_to = 1;
                    if (m_cnt != LIMIT) m_cnt = m_cnt + 1;
                    m_pend = m_pend || q;
                end
            end
        endcase
    endfunction

    function automatic logic [5:0] f_act();
        return {clkgen_en, ref_core_en, ref_detect_en, sleep_level, wake_timeout};
    endfunction

    task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", tag, act, exp);
        end
    endtask

    // One cycle: apply shadows, compare against model, advance model.
    task automatic tick(input string tag);
        @(negedge clk);
        ifd = s_ifd; con = s_con; dis = s_dis; sus = s_sus; irq = s_irq;
        st = s_st; eb = s_eb; ed = s_ed; ec = s_ec; rdy = s_rdy;
        #1;
        chk(tag, f_act(), f_exp());
        f_advance();
    endtask

    // Fixed-value check on the current outputs.
    task automatic hard(input string tag, input logic [5:0] exp);
        chk(tag, f_act(), exp);
    endtask

    task automatic set_port(input bit c, input bit d, input bit s, input bit i);
        s_con = c; s_dis = d; s_sus = s; s_irq = i;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: outputs %b expected run end", f_act());
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        set_port(1, 0, 0, 1);
        tick("R1");
        hard("R1 reset", 6'b111000);

        // R2: active port keeps the block awake.
        s_ifd = 1;
        tick("R2");
        tick("R2");
        hard("R2 active port stays awake", 6'b111000);

        // R2/R4: suspended connected port -> light sleep.
        set_port(1, 0, 1, 1);
        tick("R2");
        hard("R2 entry cycle", 6'b111000);
        tick("R4");
        hard("R4 light sleep", 6'b001010);
        hard("R3 clocks off", 6'b001010);

        // R8: unqualified connect event on disabled port.
        set_port(1, 1, 0, 1);
        s_ec = 1; tick("R8"); s_ec = 0;
        repeat (4) tick("R8");
        hard("R8 unqualified ignored", 6'b001010);

        // R5: mask interrupt on disabled port -> deep.
        s_irq = 0;
        tick("R5");
        hard("R5 deep sleep", 6'b000100);
        set_port(0, 0, 1, 1);
        tick("R5");
        hard("R5 unplugged deep", 6'b000100);

        // R7: one-cycle bias pulse on suspended port.
        set_port(1, 0, 1, 1);
        s_eb = 1; tick("R7"); s_eb = 0;
        tick("R7");
        hard("R7 still asleep one edge later", 6'b001010);
        tick("R7");
        hard("R7 waking two edges later", 6'b111110);

        // R9: clock-ready ends the wake.
        s_ifd = 0; s_rdy = 1;
        tick("R9");
        s_rdy = 0;
        tick("R9");
        hard("R9 awake again", 6'b111000);

        // R8: event while awake is not latched.
        s_eb = 1; s_ec = 1; tick("R8"); s_eb = 0; s_ec = 0;
        s_ifd = 1;
        tick("R8");
        repeat (5) tick("R8");
        hard("R8 awake event ignored", 6'b001010);

        // R6: status input wakes.
        s_st = 1;
        tick("R6");
        s_st = 0;
        tick("R6");
        hard("R6 waking", 6'b111110);

        // R10: full window without clock-ready.
        for (int k = 2; k <= LIMIT; k++) tick("R10");
        hard("R10 last cycle before timeout", 6'b111110);
        tick("R10");
        hard("R10 timeout raised", 6'b111111);
        s_ifd = 0; s_rdy = 1;
        tick("R10");
        s_rdy = 0;
        tick("R10");
        hard("R10 sticky after wake", 6'b111001);

        // R11: next sleep entry clears the flag.
        s_ifd = 1;
        tick("R11");
        tick("R11");
        hard("R11 cleared on sleep", 6'b001010);

        // R10: clock-ready in the final permitted cycle.
        s_st = 1; tick("R10"); s_st = 0;
        for (int k = 1; k < LIMIT; k++) tick("R10");
        s_ifd = 0; s_rdy = 1;
        tick("R10");
        s_rdy = 0;
        tick("R10");
        hard("R10 ready at limit no timeout", 6'b111000);

        // Random traffic against the model.
        for (int i = 0; i < 3000; i++) begin
            s_ifd = ($urandom % 10) != 0;
            s_con = $urandom % 2;
            s_dis = ($urandom % 5) == 0;
            s_sus = ($urandom % 5) < 2;
            s_irq = $urandom % 2;
            s_st  = ($urandom % 20) == 0;
            s_eb  = ($urandom % 20) == 0;
            s_ed  = ($urandom % 20) == 0;
            s_ec  = ($urandom % 20) == 0;
            s_rdy = ($urandom % 7) == 0;
            case (m_st)
                1: tick(f_deep() ? "R5" : "R4");
                2: tick("R6");
                default: tick("R2");
            endcase
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule